// File: doc/BRIEF.md
# Selectable-Ratio Divider with Side-Step

This block is a synchronous counter. It divides a stream of input enables by a ratio chosen from 1, 2, 5 or 10. In the divide-by-10 setting, one division cycle can be stretched to 11 enables on request. The block is meant to be the on-chip half of a decade divider. In the 10/11 setting it forms the whole decade by itself, using its own feedback. In the other three settings, an external prescaler must supply the complementary ratio: 10/11 against 1, 5/6 against 2, and 2/3 against 5.

A division cycle starts with the enable that arrives while the counter is at zero. At that enable the block samples both the ratio select and the side-step request. It then keeps the resulting cycle length until the cycle ends. The block has two outputs:
- `tc` is high combinationally on the enable that closes a cycle.
- `sync_n` is low for the whole input period in which the counter sits in the last state of the cycle. A following stage can use it to time its own feedback.

Top module: `sidestep_divider`

## Requirements
- R1: While `rst` is high, at a clock edge the count returns to zero. While `rst` is high, `tc` is low and `sync_n` is high.
- R2: Ratio select 2'b00 divides by 1. `tc` equals `en` and `sync_n` stays low. The side-step request has no effect in this setting.
- R3: Ratio select 2'b01 divides by 2: exactly one enable in every 2 raises `tc`.
- R4: Ratio select 2'b10 divides by 5: exactly one enable in every 5 raises `tc`.
- R5: Ratio select 2'b11 with the side-step request low at the start of the cycle gives a cycle of 10 enables.
- R6: Ratio select 2'b11 with the side-step request high on the first enable of a cycle gives a cycle of exactly 11 enables.
- R7: The side-step request is sampled only on the first enable of a cycle. Changing it later in the cycle leaves that cycle's length unchanged. It is ignored for ratio selects 2'b00, 2'b01 and 2'b10.
- R8: A change of ratio select made after the first enable of a cycle takes effect only at the next cycle. The current cycle ends at its originally sampled length.
- R9: `sync_n` is low exactly while the counter is in the last state of its cycle. `tc` is high only when `en` is high in that state. The count is zero after an edge at which `tc` was high.
- R10: While `en` is low, the count and the sampled cycle length do not change and `tc` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Input period enable; one count per high cycle |
| ratio_sel | input | 2 | Ratio select: 00 = 1, 01 = 2, 10 = 5, 11 = 10 or 11 |
| step_req | input | 1 | Side-step request; lengthens a 10 cycle to 11 |
| tc | output | 1 | Terminal count; high on the enable that ends a cycle |
| sync_n | output | 1 | Active-low marker of the last input period of a cycle |

## Verification
The bench builds the block with its default parameters: a 4-bit count and ratios of 1, 2, 5 and 10. At these values the longest cycle, 11 enables, fits in the counter with room to spare. Every cycle length the select offers is therefore reached many times within a few thousand vectors.

Several situations are covered:
- Random enable gaps stretch cycles across idle clocks.
- Mid-cycle toggles of the ratio and side-step inputs test the rule that inputs are sampled once per cycle.
- Resets land at arbitrary count positions.

// File: rtl/sidestep_divider.sv
module sidestep_divider #(
  parameter int CNT_W   = 4,
  parameter int RATIO_0 = 1,
  parameter int RATIO_1 = 2,
  parameter int RATIO_2 = 5,
  parameter int RATIO_3 = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       ratio_sel,
  input  logic             step_req,
  output logic             tc,
  output logic             sync_n
);

  localparam int MAX_LEN = RATIO_3 + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] len_live;
  logic [CNT_W-1:0] len_now;
  logic             at_start;
  logic             at_last;

  always_comb begin
    case (ratio_sel)
      2'b00:   len_live = CNT_W'(RATIO_0);
      2'b01:   len_live = CNT_W'(RATIO_1);
      2'b10:   len_live = CNT_W'(RATIO_2);
      default: len_live = CNT_W'(RATIO_3) + CNT_W'(step_req);
    endcase
  end

  assign at_start = (cnt == '0);
  assign len_now  = at_start ? len_live : len_q;
  assign at_last  = (cnt == len_now - CNT_W'(1));

  assign tc     = en & at_last & ~rst;
  assign sync_n = rst | ~at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      len_q <= CNT_W'(RATIO_0);
    end else if (en) begin
      if (at_start) len_q <= len_live;
      cnt <= at_last ? '0 : cnt + CNT_W'(1);
    end
  end

  AST_TC_IN_LAST: assert property (@(posedge clk) disable iff (rst)
    tc |-> !sync_n);  // R9
  AST_WRAP_ON_TC: assert property (@(posedge clk) disable iff (rst)
    tc |=> (cnt == '0));  // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(cnt) && $stable(len_q)));  // R10
  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(len_q));  // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(MAX_LEN));  // R6
  AST_UNIT_EVERY: assert property (@(posedge clk) disable iff (rst)
    (en && ratio_sel == 2'b00 && cnt == '0) |-> tc);  // R2

endmodule

// File: tb/tb_sidestep_divider.sv
module tb_sidestep_divider;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [1:0] ratio_sel = 2'b00;
  logic step_req = 1'b0;
  logic tc, sync_n;

  int vectors = 0;
  int miscompares = 0;
  int pos = 0;
  int cur_len = 1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sidestep_divider dut (
    .clk(clk), .rst(rst), .en(en), .ratio_sel(ratio_sel),
    .step_req(step_req), .tc(tc), .sync_n(sync_n)
  );

  function automatic int len_of(input logic [1:0] r, input logic s);
    case (r)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 5;
      default: return s ? 11 : 10;
    endcase
  endfunction

  task automatic apply(input logic r_rst, input logic r_en, input logic [1:0] r_sel,
                       input logic r_step, input string req);
    int  live;
    bit  last, exp_tc, exp_sync;
    @(negedge clk);
    rst = r_rst; en = r_en; ratio_sel = r_sel; step_req = r_step;
    #1;
    live = (pos == 0) ? len_of(r_sel, r_step) : cur_len;
    last = (pos == live - 1);
    exp_tc   = r_rst ? 1'b0 : (r_en && last);
    exp_sync = r_rst ? 1'b1 : !last;
    vectors++;
    if (tc !== exp_tc || sync_n !== exp_sync) begin
      miscompares++;
      $display("FAIL %s: tc=%b sync_n=%b expected tc=%b sync_n=%b (pos %0d len %0d)",
               req, tc, sync_n, exp_tc, exp_sync, pos, live);
    end
    if (r_rst) pos = 0;
    else if (r_en) begin
      if (pos == 0) cur_len = live;
      pos = last ? 0 : pos + 1;
    end
  endtask

  task automatic count_cycle(input logic [1:0] sel, input logic step, input int want,
                             input string req);
    int n = 0;
    bit seen = 0;
    while (!seen && n < 20) begin
      apply(1'b0, 1'b1, sel, step, req);
      n++;
      if (tc === 1'b1) seen = 1;
    end
    vectors++;
    if (n != want) begin
      miscompares++;
      $display("FAIL %s: cycle length %0d expected %0d", req, n, want);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4751));
    // R1 reset state
    repeat (3) apply(1'b1, 1'b1, 2'b11, 1'b1, "R1");
    // R2 divide by 1, step ignored
    for (int i = 0; i < 20; i++) apply(1'b0, 1'($urandom), 2'b00, 1'($urandom), "R2");
    // R3, R4 fixed ratios with random step (R7 ignored)
    for (int i = 0; i < 4; i++) count_cycle(2'b01, 1'($urandom), 2, "R3");
    for (int i = 0; i < 4; i++) count_cycle(2'b10, 1'($urandom), 5, "R4");
    // R5 / R6 decade and side-step
    for (int i = 0; i < 3; i++) count_cycle(2'b11, 1'b0, 10, "R5");
    for (int i = 0; i < 3; i++) count_cycle(2'b11, 1'b1, 11, "R6");
    // R7 step raised after start: 10 expected
    apply(1'b0, 1'b1, 2'b11, 1'b0, "R7");
    for (int i = 0; i < 8; i++) apply(1'b0, 1'b1, 2'b11, 1'b1, "R7");
    apply(1'b0, 1'b1, 2'b11, 1'b1, "R7");
    vectors++;
    if (tc !== 1'b1) begin
      miscompares++;
      $display("FAIL R7: tc=%b at 10th enable expected 1", tc);
    end
    // R8 ratio change mid-cycle
    apply(1'b0, 1'b1, 2'b10, 1'b0, "R8");
    for (int i = 0; i < 6; i++) apply(1'b0, 1'b1, 2'b01, 1'b0, "R8");
    // R10 idle clocks
    for (int i = 0; i < 10; i++) apply(1'b0, 1'b0, 2'($urandom), 1'($urandom), "R10");
    // Random phase: R9 with all others
    for (int blk = 0; blk < 400; blk++) begin
      logic [1:0] sel = 2'($urandom);
      int span = 1 + int'($urandom_range(0, 25));
      for (int i = 0; i < span; i++)
        apply(($urandom_range(0, 199) == 0), ($urandom_range(0, 9) < 8), sel,
              1'($urandom), "R9");
      if ($urandom_range(0, 3) == 0) sel = 2'($urandom);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule